// File: doc/BRIEF.md
# Receiver Wake and Polling Controller

This block sequences the operating mode of a polled radio receiver. In normal polling the receiver sleeps for a programmed interval, spends a fixed number of ticks starting up, and then lets an external bit-check circuit decide whether a valid signal is present. A good result promotes the receiver to receiving mode. A bad result sends it back to sleep with a fresh interval. All timing counts ticks of an external timebase strobe, so one clock domain serves any tick rate.

A host can take over through an active-low force-on pin. Holding the pin low wakes the receiver and carries it into receiving mode without a bit check. The programmed sleep code and bit-check count are ignored meanwhile, but they are left intact. Holding the pin low long enough and then releasing it returns the receiver to polling after a short delay. One sleep code, all ones, disables timer wake-up entirely, so that only the pin can wake the receiver.

Top module: `rx_wake_ctrl`

## Requirements
- R1: Reset puts the block in sleep. `mode_o` encodes sleep as 0, start-up as 1, bit check as 2 and receiving as 3. `fe_en_o` is high exactly when `mode_o` is not 0. `sleep_done_o` is low in reset.
- R2: With the pin high, sleep lasts (code+1)×SLEEP_UNIT ticks. It ends in start-up, and `sleep_done_o` is high for exactly the first start-up cycle.
- R3: With the pin high and the sleep code all ones (31), the timer never ends sleep and `sleep_done_o` stays low.
- R4: The sleep timer advances only on a tick while the pin is high. With the pin low or no tick, the remaining interval is held.
- R5: Start-up lasts STARTUP_TICKS ticks. It then moves to bit check if the pin is high, or straight to receiving if the pin is low.
- R6: In bit check, the block enters receiving after `bit_need_i` pass strobes. A count of 0 acts as 1.
- R7: A fail strobe in bit check returns the block to sleep with a full fresh interval.
- R8: Once the pin has been low for TON1 ticks, sleep moves to start-up on the next clock without a `sleep_done_o` pulse. Bit check moves to receiving on the next clock, and pass and fail strobes are ignored.
- R9: Pin activity never alters the programmed fields. After a pin-driven episode, the next sleep interval again follows the sleep code.
- R10: A low period of at least TON2 ticks, followed by the rising edge of the pin, puts the block into sleep TON3 ticks after the rise, with a fresh interval. At one tick per clock, the old mode is seen for TON3+1 cycles counted from the release.
- R11: A low period shorter than TON2 ticks does not start the return to polling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Timebase strobe, one clock wide |
| force_on_n_i | input | 1 | Active-low force-on pin, synchronous to clk |
| sleep_code_i | input | CODE_W | Programmed sleep-time code |
| bit_need_i | input | BITCNT_W | Programmed number of passes for the bit check |
| bit_pass_i | input | 1 | Bit-check pass strobe |
| bit_fail_i | input | 1 | Bit-check fail strobe |
| mode_o | output | 2 | Current mode |
| fe_en_o | output | 1 | Front-end enable |
| sleep_done_o | output | 1 | Sleep-timer expiry strobe |

## Verification
Most internal faults in this block appear as a mode interval of the wrong length. A misloaded or mis-gated sleep counter moves the first start-up cycle by whole ticks. A wrong start-up or pin counter shifts the following transition. The bench therefore measures every dwell time in sleep, start-up and the return delay to the exact cycle, sweeping many sleep codes and bit counts. A stale armed or pending return flag shows up within TON3+1 cycles of a pin release, as an unexpected or missing drop to sleep.

// File: rtl/rwp_pkg.sv
// Shared types for the receiver wake and polling controller.
// Assumes a two-bit mode field observed by neighbouring logic.
package rwp_pkg;
    typedef enum logic [1:0] {
        MODE_SLEEP   = 2'd0,
        MODE_STARTUP = 2'd1,
        MODE_BITCHK  = 2'd2,
        MODE_RECEIVE = 2'd3
    } mode_e;
endpackage

// File: rtl/rwp_pin_timer.sv
// Measures how long the force-on pin has been low (in ticks) and runs the
// return-to-polling delay after a qualifying release.
// Assumes the pin is already synchronous to clk and TON1, TON2, TON3 >= 1.
module rwp_pin_timer #(
    parameter int TON1 = 3,
    parameter int TON2 = 6,
    parameter int TON3 = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pin_n_i,
    output logic forced_o,
    output logic ret_go_o
);
    localparam int LOW_MAX = (TON1 > TON2) ? TON1 : TON2;
    localparam int LOW_W   = $clog2(LOW_MAX + 1);
    localparam int RET_W   = $clog2(TON3 + 1);

    logic [LOW_W-1:0] low_cnt;
    logic [RET_W-1:0] ret_cnt;
    logic             pin_q;
    logic             pend;
    logic             rise;
    logic             armed;

    assign rise     = pin_n_i && !pin_q;
    assign armed    = low_cnt >= LOW_W'(TON2);
    assign forced_o = !pin_n_i && (low_cnt >= LOW_W'(TON1));
    assign ret_go_o = pend && tick_i && (ret_cnt == RET_W'(TON3 - 1));

    // Saturating count of ticks seen while the pin is low.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       low_cnt <= '0;
        else if (pin_n_i)                                 low_cnt <= '0;
        else if (tick_i && low_cnt != LOW_W'(LOW_MAX))    low_cnt <= low_cnt + 1'b1;
    end

    // Previous pin level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b1;
        else        pin_q <= pin_n_i;
    end

    // Return-to-polling delay, started by a release after a long enough low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            ret_cnt <= '0;
        end else if (rise && armed) begin
            pend    <= 1'b1;
            ret_cnt <= '0;
        end else if (ret_go_o) begin
            pend    <= 1'b0;
        end else if (pend && tick_i) begin
            ret_cnt <= ret_cnt + 1'b1;
        end
    end

    p_low_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pin_n_i |=> (low_cnt == '0));
    p_ret_armed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(armed));
endmodule

// File: rtl/rwp_sleep_timer.sv
// Down-counter for the sleep interval of (code+1)*SLEEP_UNIT ticks.
// It counts only while sleeping, on a tick, with the pin high. The all-ones code never expires.
// Assumes the controller asserts load on every entry into sleep.
module rwp_sleep_timer #(
    parameter int CODE_W     = 5,
    parameter int SLEEP_UNIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              pin_n_i,
    input  logic              run_i,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              expire_o
);
    localparam int SLP_W = $clog2((2 ** CODE_W) * SLEEP_UNIT + 1);

    logic [SLP_W-1:0] cnt;
    logic [SLP_W-1:0] load_val;
    logic             step;
    logic             perm;

    assign load_val = (SLP_W'(code_i) + SLP_W'(1)) * SLP_W'(SLEEP_UNIT);
    assign perm     = &code_i;
    assign step     = run_i && tick_i && pin_n_i;
    assign expire_o = step && (cnt == SLP_W'(1)) && !perm;

    // Load on reset or sleep entry, otherwise count down toward one.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i)             cnt <= load_val;
        else if (step && cnt > SLP_W'(1)) cnt <= cnt - 1'b1;
    end

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !(tick_i && pin_n_i)) |=> $stable(cnt));
endmodule

// File: rtl/rx_wake_ctrl.sv
// Mode sequencer for a polled receiver. It cycles through sleep, start-up, bit check and receiving.
// A force-on pin can override the programmed sleep and bit-check settings.
// Assumes the tick, pin and strobes are synchronous to clk. The timing parameters are >= 1.
module rx_wake_ctrl
    import rwp_pkg::*;
#(
    parameter int CODE_W        = 5,
    parameter int BITCNT_W      = 3,
    parameter int SLEEP_UNIT    = 4,
    parameter int STARTUP_TICKS = 5,
    parameter int TON1          = 3,
    parameter int TON2          = 6,
    parameter int TON3          = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                force_on_n_i,
    input  logic [CODE_W-1:0]   sleep_code_i,
    input  logic [BITCNT_W-1:0] bit_need_i,
    input  logic                bit_pass_i,
    input  logic                bit_fail_i,
    output logic [1:0]          mode_o,
    output logic                fe_en_o,
    output logic                sleep_done_o
);
    localparam int SU_W  = $clog2(STARTUP_TICKS + 1);
    localparam int SEQ_W = (SU_W > BITCNT_W + 1) ? SU_W : BITCNT_W + 1;

    mode_e             state, nxt;
    logic [SEQ_W-1:0]  seq;
    logic [SEQ_W-1:0]  need;
    logic              forced, ret_go, expire, load, took_expire;

    rwp_pin_timer #(.TON1(TON1), .TON2(TON2), .TON3(TON3)) u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .pin_n_i  (force_on_n_i),
        .forced_o (forced),
        .ret_go_o (ret_go)
    );

    rwp_sleep_timer #(.CODE_W(CODE_W), .SLEEP_UNIT(SLEEP_UNIT)) u_slp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .pin_n_i  (force_on_n_i),
        .run_i    (state == MODE_SLEEP),
        .load_i   (load),
        .code_i   (sleep_code_i),
        .expire_o (expire)
    );

    assign need = (bit_need_i == '0) ? SEQ_W'(1) : SEQ_W'(bit_need_i);

    // Next mode: the return delay wins, then the pin override, then the normal sequence.
    always_comb begin
        nxt         = state;
        took_expire = 1'b0;
        if (ret_go) begin
            nxt = MODE_SLEEP;
        end else begin
            case (state)
                MODE_SLEEP: begin
                    if (forced) begin
                        nxt = MODE_STARTUP;
                    end else if (expire) begin
                        nxt         = MODE_STARTUP;
                        took_expire = 1'b1;
                    end
                end
                MODE_STARTUP: begin
                    if (tick_i && seq == SEQ_W'(STARTUP_TICKS - 1))
                        nxt = force_on_n_i ? MODE_BITCHK : MODE_RECEIVE;
                end
                MODE_BITCHK: begin
                    if (forced)                                  nxt = MODE_RECEIVE;
                    else if (bit_fail_i)                         nxt = MODE_SLEEP;
                    else if (bit_pass_i && seq == need - 1'b1)   nxt = MODE_RECEIVE;
                end
                default: nxt = state;
            endcase
        end
    end

    assign load = ret_go || (nxt == MODE_SLEEP && state != MODE_SLEEP);

    // Mode register and expiry strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= MODE_SLEEP;
            sleep_done_o <= 1'b0;
        end else begin
            state        <= nxt;
            sleep_done_o <= took_expire;
        end
    end

    // Shared sequence counter: start-up ticks, or bit-check passes.
    always_ff @(posedge clk) begin
        if (!rst_n || nxt != state || ret_go)                  seq <= '0;
        else if (state == MODE_STARTUP && tick_i)              seq <= seq + 1'b1;
        else if (state == MODE_BITCHK && bit_pass_i && !forced) seq <= seq + 1'b1;
    end

    assign mode_o  = state;
    assign fe_en_o = (state != MODE_SLEEP);

    p_done_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_done_o |-> (state == MODE_STARTUP && $past(state) == MODE_SLEEP));
    p_perm_sleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_SLEEP && (&sleep_code_i) && force_on_n_i && !ret_go)
            |=> (state == MODE_SLEEP && !sleep_done_o));
    p_skip_check_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_RECEIVE && $past(state) == MODE_STARTUP) |-> $past(!force_on_n_i));
    p_fail_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_BITCHK && bit_fail_i && !forced && !ret_go) |=> (state == MODE_SLEEP));
    p_forced_check_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_BITCHK && forced && !ret_go) |=> (state == MODE_RECEIVE));
endmodule

// File: tb/rx_wake_ctrl_tb.sv
module rx_wake_ctrl_tb;
    localparam int UNIT = 4, SU = 5, T1 = 3, T2 = 6, T3 = 2;
    localparam int M_SLEEP = 0, M_START = 1, M_CHECK = 2, M_RECV = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0, tick = 1'b1, pin_n = 1'b1, pass = 1'b0, fail = 1'b0;
    logic [4:0] code = '0;
    logic [2:0] need = '0;
    logic [1:0] mode;
    logic fe_en, sdone;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    rx_wake_ctrl #(.CODE_W(5), .BITCNT_W(3), .SLEEP_UNIT(UNIT), .STARTUP_TICKS(SU),
                   .TON1(T1), .TON2(T2), .TON3(T3)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .force_on_n_i(pin_n),
        .sleep_code_i(code), .bit_need_i(need), .bit_pass_i(pass), .bit_fail_i(fail),
        .mode_o(mode), .fe_en_o(fe_en), .sleep_done_o(sdone));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int c, input int b);
        code = 5'(c); need = 3'(b); pin_n = 1'b1; pass = 0; fail = 0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic dwell(input int m, output int n);
        n = 0;
        while (int'(mode) == m && n < 3000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_pass();
        pass = 1'b1; @(negedge clk); pass = 1'b0;
    endtask

    task automatic stay(input int m, input int cyc, input string req);
        bit ok = 1'b1;
        for (int i = 0; i < cyc; i++) begin
            if (int'(mode) != m || sdone) ok = 1'b0;
            @(negedge clk);
        end
        check(ok, req, int'(mode), m);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int codes[8] = '{0, 1, 2, 3, 5, 7, 12, 30};
        // R1 reset state
        code = 5'd3; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(mode == 2'(M_SLEEP) && !fe_en && !sdone, "R1 reset", int'(mode), M_SLEEP);

        // R2 R5 R6 R1 sweep over sleep codes and bit counts
        foreach (codes[i]) begin
            int c = codes[i];
            int b = i % 5;
            int nb = (b == 0) ? 1 : b;
            do_reset(c, b);
            dwell(M_SLEEP, n);
            check(n == (c + 1) * UNIT, "R2 sleep length", n, (c + 1) * UNIT);
            check(sdone && mode == 2'(M_START) && fe_en, "R2 done strobe", int'(sdone), 1);
            @(negedge clk);
            check(!sdone, "R2 strobe width", int'(sdone), 0);
            dwell(M_START, n);
            check(n == SU - 1, "R5 startup length", n + 1, SU);
            check(mode == 2'(M_CHECK), "R5 to bit check", int'(mode), M_CHECK);
            for (int k = 0; k < nb - 1; k++) pulse_pass();
            check(mode == 2'(M_CHECK), "R6 not yet", int'(mode), M_CHECK);
            pulse_pass();
            check(mode == 2'(M_RECV) && fe_en, "R6 passes reached", int'(mode), M_RECV);
        end

        // R7 fail returns to sleep with fresh interval
        do_reset(1, 3);
        dwell(M_SLEEP, n); dwell(M_START, n);
        pulse_pass();
        fail = 1'b1; @(negedge clk); fail = 1'b0;
        dwell(M_SLEEP, n);
        check(n == 2 * UNIT, "R7 fail to sleep", n, 2 * UNIT);

        // R4 no tick holds the timer
        tick = 1'b0;
        do_reset(0, 1);
        stay(M_SLEEP, 50, "R4 tick held");
        tick = 1'b1;
        dwell(M_SLEEP, n);
        check(n == UNIT, "R4 resumes", n, UNIT);

        // R4 pin low holds the timer
        do_reset(2, 1);
        repeat (3) @(negedge clk);
        pin_n = 1'b0; repeat (2) @(negedge clk); pin_n = 1'b1;
        dwell(M_SLEEP, n);
        check(n == 3 * UNIT - 3, "R4 pin low hold", n, 3 * UNIT - 3);

        // R3 permanent sleep, R8 pin wake, R10 return, R3 again
        do_reset(31, 2);
        stay(M_SLEEP, 400, "R3 permanent");
        pin_n = 1'b0;
        dwell(M_SLEEP, n);
        check(n == T1 + 1, "R8 wake delay", n, T1 + 1);
        check(!sdone, "R8 no strobe", int'(sdone), 0);
        dwell(M_START, n);
        check(mode == 2'(M_RECV), "R5 skip check", int'(mode), M_RECV);
        pin_n = 1'b1;
        dwell(M_RECV, n);
        check(n == T3 + 1 && mode == 2'(M_SLEEP), "R10 return delay", n, T3 + 1);
        stay(M_SLEEP, 200, "R3 after return");

        // R9 R10 fields kept through pin episode
        do_reset(4, 3);
        pin_n = 1'b0;
        dwell(M_SLEEP, n); dwell(M_START, n);
        repeat (4) @(negedge clk);
        pin_n = 1'b1;
        dwell(M_RECV, n);
        check(n == T3 + 1, "R10 return delay 2", n, T3 + 1);
        dwell(M_SLEEP, n);
        check(n == 5 * UNIT, "R9 interval kept", n, 5 * UNIT);
        check(mode == 2'(M_START) && sdone, "R9 timer wake", int'(mode), M_START);

        // R11 short low ignored, TON2 boundary returns
        do_reset(0, 1);
        dwell(M_SLEEP, n); dwell(M_START, n); pulse_pass();
        check(mode == 2'(M_RECV), "R6 count one", int'(mode), M_RECV);
        pin_n = 1'b0; repeat (T2 - 1) @(negedge clk); pin_n = 1'b1;
        stay(M_RECV, 40, "R11 short low");
        pin_n = 1'b0; repeat (T2) @(negedge clk); pin_n = 1'b1;
        dwell(M_RECV, n);
        check(n == T3 + 1, "R10 boundary", n, T3 + 1);
        dwell(M_SLEEP, n);
        check(n == UNIT, "R10 fresh interval", n, UNIT);

        // R8 pin forces bit check to receiving, strobes ignored
        do_reset(0, 3);
        dwell(M_SLEEP, n); dwell(M_START, n);
        pin_n = 1'b0;
        dwell(M_CHECK, n);
        check(n == T1 + 1 && mode == 2'(M_RECV), "R8 check bypass", n, T1 + 1);
        pin_n = 1'b1;
        fail = 1'b1; @(negedge clk); fail = 1'b0;
        stay(M_RECV, 30, "R11 stays receiving");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule